// File: doc/BRIEF.md
# Transition-Kicked Watchdog Timer

This block supervises a processor through a single kick line. The processor toggles the line during normal operation, and either a rising or a falling edge restarts a countdown. If the countdown runs out before another edge arrives, the active-low watchdog output drops. It then stays low until the next edge of either polarity. Time is measured in ticks of an external enable, and the timeout length is the parameter `TIMEOUT_TICKS`. With a 1 ms tick, the default of 1600 gives the nominal 1.6 s window.

While the system is held in reset, or while an external detector reports that the kick line is floating, the timer is kept cleared and idle. After such a hold ends, the timer stays disarmed until the first edge. A separate undervoltage flag forces the output low through a purely combinational path, and the output recovers the moment the flag clears. With the kick line floating, the output therefore only reports low supply. Any wiring of the output into a manual reset is done outside the block.

Top module: `kick_watchdog`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `wdo_n` is high and the timer is disarmed.
- R2: A rising edge and a falling edge of `kick` both restart the countdown from zero. Kicks spaced closer than `TIMEOUT_TICKS` ticks keep `wdo_n` high.
- R3: A change on `kick` is seen as an edge through a two-flop synchronizer, and the edge takes effect on the third rising clock edge after the change. If `TIMEOUT_TICKS` ticks then pass with no further edge, `wdo_n` goes low on the clock that counts the last tick.
- R4: After a timeout, `wdo_n` stays low until the next edge of either polarity. It returns high on the third clock after that `kick` change.
- R5: While `sys_rst_act` is high, the counter is held at zero, any pending timeout is cleared on the next clock, and edges on `kick` are ignored.
- R6: After a hold ends, no counting takes place until the first `kick` edge.
- R7: While `kick_float` is high, the timer is held exactly as in R5, and `wdo_n` stays high as long as `undervolt` is low.
- R8: `undervolt` high drives `wdo_n` low in the same cycle with no clock delay, and `wdo_n` follows the timer state again as soon as `undervolt` falls.
- R9: When an edge takes effect in the same cycle as the terminal tick, the edge wins. `wdo_n` stays high and a fresh countdown starts.
- R10: The counter advances only on clocks where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| tick | input | 1 | Time-base enable, one clock wide per tick |
| kick | input | 1 | Asynchronous kick line from the processor |
| kick_float | input | 1 | High while the kick line is sensed as floating |
| sys_rst_act | input | 1 | High while system reset is asserted |
| undervolt | input | 1 | High while the supply is below threshold |
| wdo_n | output | 1 | Active-low watchdog output |

## Verification
A `kick` change made after clock c takes effect at clock c+3, which accounts for two synchronizer flops and the edge-capture register. A timeout after an edge at c is therefore due at c+`TIMEOUT_TICKS`+3, and recovery after a fresh edge is due at c+3. A hold or a `tick` change lands one clock after it is driven, and `undervolt` acts before the next clock. The driver turns each stimulus into expected values stamped with their exact due cycle, including the cycle just before each transition. The monitor samples 5 ns after every rising edge and compares only the entries whose stamp matches the current cycle.

// File: rtl/kick_watchdog.sv
module kick_watchdog #(
  parameter int TIMEOUT_TICKS = 1600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic kick,
  input  logic kick_float,
  input  logic sys_rst_act,
  input  logic undervolt,
  output logic wdo_n
);

  localparam int CW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

  logic [2:0]    sync_q;
  logic          armed_q, expired_q;
  logic [CW-1:0] cnt_q;

  wire hold     = sys_rst_act | kick_float;
  wire kick_edg = sync_q[1] ^ sync_q[2];
  wire terminal = armed_q & tick & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], kick};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      expired_q <= 1'b0;
      cnt_q     <= '0;
    end else if (hold) begin
      armed_q   <= 1'b0;
      expired_q <= 1'b0;
      cnt_q     <= '0;
    end else if (kick_edg) begin
      armed_q   <= 1'b1;
      expired_q <= 1'b0;
      cnt_q     <= '0;
    end else if (armed_q && tick && !expired_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (terminal) expired_q <= 1'b1;
    end
  end

  assign wdo_n = ~(expired_q | undervolt);

  // R5 / R7: hold clears the timer
  a_r5_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt_q == '0) && !expired_q && !armed_q);

  // R4: a timeout persists until an edge or a hold
  a_r4_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdo_n && !undervolt && !kick_edg && !hold) |=> !wdo_n);

  // R9: an edge beats the terminal tick
  a_r9_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_edg && !hold) |=> (cnt_q == '0) && !expired_q);

  // R3: the terminal tick with no edge drops the output
  a_r3_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (terminal && !expired_q && !kick_edg && !hold) |=> !wdo_n);

  // R6: a disarmed timer does not count
  a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !kick_edg) |=> (cnt_q == '0) && !expired_q);

  // R10: no tick, no progress
  a_r10_tick_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !kick_edg && !hold) |=> $stable(cnt_q));

endmodule

// File: tb/kick_watchdog_tb_top.sv
`timescale 1ns/1ps
module kick_watchdog_tb_top;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n, tick, kick, kick_float, sys_rst_act, undervolt;
  logic wdo_n;

  int cyc = 0;
  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  int    due_q[$];
  bit    val_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  kick_watchdog #(.TIMEOUT_TICKS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick),
    .kick_float(kick_float), .sys_rst_act(sys_rst_act),
    .undervolt(undervolt), .wdo_n(wdo_n)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #5;
    while (due_q.size() > 0 && due_q[0] <= cyc) begin
      int d; bit v; string t;
      d = due_q.pop_front(); v = val_q.pop_front(); t = tag_q.pop_front();
      vectors++;
      if (d != cyc || wdo_n !== v) begin
        miscompares++;
        $display("FAIL %s cycle %0d (due %0d): wdo_n actual %b expected %b",
                 t, cyc, d, wdo_n, v);
      end
    end
  end

  task automatic at(input int d, input bit v, input string t);
    due_q.push_back(d); val_q.push_back(v); tag_q.push_back(t);
  endtask

  task automatic window(input int a, input int b, input bit v, input string t);
    for (int i = a; i <= b; i++) at(i, v, t);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle(output int c);
    @(negedge clk);
    kick = ~kick;
    c = cyc;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run hung, actual running expected done");
      finish_run();
    end
  end

  initial begin
    int c, c2, u, r, t;
    rst_n = 1'b0; tick = 1'b1; kick = 1'b0; kick_float = 1'b0;
    sys_rst_act = 1'b1; undervolt = 1'b0;
    idle(3);
    rst_n = 1'b1; c = cyc;
    at(c + 1, 1'b1, "R1");

    // R5: edges during system reset are ignored
    toggle(c); idle(3); toggle(c);
    window(c + 1, c + 20, 1'b1, "R5");
    idle(22);

    // R6: release reset, no counting without an edge
    @(negedge clk); sys_rst_act = 1'b0; c = cyc;
    window(c + 1, c + 20, 1'b1, "R6");
    idle(21);

    // R3: first edge arms, timeout after N ticks
    toggle(c);
    at(c + N + 2, 1'b1, "R3"); at(c + N + 3, 1'b0, "R3");
    idle(N + 4);

    // R4: latched low, falling edge releases; R2 falling edge restarts
    window(cyc + 1, cyc + 15, 1'b0, "R4");
    idle(16);
    toggle(c);
    at(c + 2, 1'b0, "R4"); at(c + 3, 1'b1, "R4");
    at(c + N + 2, 1'b1, "R2"); at(c + N + 3, 1'b0, "R2");
    idle(N + 5);

    // R2: periodic kicks keep the output high
    toggle(c);
    at(c + 3, 1'b1, "R4");
    for (int k = 0; k < 6; k++) begin
      idle(4); toggle(c);
      at(c + 2, 1'b1, "R2");
    end
    at(c + N + 2, 1'b1, "R2"); at(c + N + 3, 1'b0, "R2");
    idle(N + 5);

    // R9: edge coincides with terminal tick
    toggle(c);
    at(c + 3, 1'b1, "R4");
    idle(N - 1);
    toggle(c2);
    at(c2 + 3, 1'b1, "R9");
    at(c2 + N + 2, 1'b1, "R9"); at(c2 + N + 3, 1'b0, "R9");
    idle(N + 5);

    // R7: floating input clears and holds
    @(negedge clk); kick_float = 1'b1; c = cyc;
    at(c + 1, 1'b1, "R7");
    idle(2); toggle(c); idle(3); toggle(c);
    window(c + 1, c + 20, 1'b1, "R7");
    idle(21);
    @(negedge clk); kick_float = 1'b0; c = cyc;
    window(c + 1, c + 20, 1'b1, "R6");
    idle(21);
    toggle(c);
    at(c + N + 2, 1'b1, "R6"); at(c + N + 3, 1'b0, "R6");
    idle(N + 5);

    // R8: undervoltage acts without delay
    toggle(c);
    at(c + 3, 1'b1, "R4");
    idle(3);
    @(negedge clk); undervolt = 1'b1; u = cyc;
    at(u + 1, 1'b0, "R8"); at(u + 2, 1'b0, "R8");
    idle(2); undervolt = 1'b0; r = cyc;
    at(r + 1, 1'b1, "R8");
    at(c + N + 2, 1'b1, "R3"); at(c + N + 3, 1'b0, "R3");
    idle(N + 5);

    // R10: no tick, no countdown
    @(negedge clk); tick = 1'b0;
    toggle(c);
    at(c + 3, 1'b1, "R4");
    window(c + 4, c + 3 * N, 1'b1, "R10");
    idle(3 * N);
    @(negedge clk); tick = 1'b1; t = cyc;
    at(t + N - 1, 1'b1, "R10"); at(t + N, 1'b0, "R10");
    idle(N + 3);

    // R5: system reset clears a pending timeout, re-arm afterwards
    @(negedge clk); sys_rst_act = 1'b1; c = cyc;
    at(c + 1, 1'b1, "R5");
    idle(2); sys_rst_act = 1'b0;
    toggle(c);
    at(c + N + 2, 1'b1, "R6"); at(c + N + 3, 1'b0, "R6");
    idle(N + 6);

    finished = 1'b1;
    finish_run();
  end
endmodule